// File: doc/BRIEF.md
# Bit-Addressable I/O Register Space

This block holds the 64-location I/O register space of a small 8-bit microcontroller core. The core moves whole bytes in and out of it with IN-style reads and OUT-style writes, addressed by a 6-bit I/O address. It can also set, clear or test a single bit of a register in one operation. These single-bit operations are legal only in the lower half of the space, at addresses 0x00 to 0x1F.

Eleven locations are implemented. Ten of them are plain read/write storage bytes that reset to zero. The storage bytes sit at 0x3F (status), 0x3B and 0x3A (interrupt mask and flag), 0x39 and 0x38 (timer interrupt mask and flag), 0x33 and 0x32 (timer control and count), 0x18 and 0x17 (port data and direction), and 0x08 (comparator control). The eleventh location, 0x16, is a read-only byte that captures an external pin bus on every clock. Every other address is reserved: it reads as zero and ignores writes. A bit operation aimed at the upper half of the space does nothing and raises a one-cycle flag.

Operations are selected on `op`, with these encodings: 0 idle, 1 IN (read), 2 OUT (write), 3 bit set, 4 bit clear, 5 bit test. Reads and tests are combinational in the cycle the operation is presented. Writes and bit updates take effect at the next rising clock edge.

Top module: `io_reg_space`

## Requirements
- R1: After the asynchronous active-low reset, every storage location reads 0x00 and `illegal_op` is 0.
- R2: OUT (op=2) to a storage location replaces its byte at the next clock edge. IN (op=1) to that location then returns the byte on `rdata` in the same cycle.
- R3: IN from a reserved address (none of 0x3F, 0x3B, 0x3A, 0x39, 0x38, 0x33, 0x32, 0x18, 0x17, 0x16, 0x08) returns 0x00.
- R4: OUT to a reserved address changes no implemented location.
- R5: Bit set (op=3) at an address below 0x20 forces bit `bit_idx` of that storage byte to 1 at the next edge and leaves its other seven bits unchanged.
- R6: Bit clear (op=4) at an address below 0x20 forces bit `bit_idx` to 0 at the next edge and leaves the other bits unchanged.
- R7: Bit test (op=5) at an address below 0x20 drives `test_bit` with bit `bit_idx` of the location's read value in the same cycle. `test_bit` is 0 for any other operation and for any test at or above 0x20.
- R8: A bit set, clear or test at an address of 0x20 or above changes no location. It drives `illegal_op` high for exactly the one cycle after the operation is issued.
- R9: Location 0x16 reads the value `pins_in` held at the preceding clock edge. OUT, bit set and bit clear aimed at 0x16 have no effect.
- R10: `rdata` is 0x00 whenever `op` is not IN.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 6 | I/O address of the operation |
| op | input | 3 | Operation: 0 idle, 1 IN, 2 OUT, 3 set bit, 4 clear bit, 5 test bit |
| bit_idx | input | 3 | Bit number used by set, clear and test |
| wdata | input | 8 | Byte written by OUT |
| pins_in | input | 8 | External pin levels captured into location 0x16 |
| rdata | output | 8 | Byte returned by IN, zero otherwise |
| test_bit | output | 1 | Result of a legal bit test |
| illegal_op | output | 1 | One-cycle pulse after a bit operation in the upper half |

## Verification
A corrupted storage byte stays hidden until the core reads it. It then shows up on `rdata` in the same cycle as the IN, or on `test_bit` in the same cycle as a test of the affected bit. A write or bit update that lands on the wrong location, or that reaches a reserved or upper-half address, only shows on a later read of the location it damaged. For that reason every address is read back after each sweep of writes and bit operations. A wrong `illegal_op` state shows up one cycle after the offending operation.

// File: rtl/io_space_pkg.sv
package io_space_pkg;
  localparam int ADDR_W    = 6;
  localparam int DATA_W    = 8;
  localparam int BIDX_W    = $clog2(DATA_W);
  localparam int NUM_STORE = 10;

  typedef enum logic [2:0] {
    OP_IDLE = 3'd0,
    OP_IN   = 3'd1,
    OP_OUT  = 3'd2,
    OP_BSET = 3'd3,
    OP_BCLR = 3'd4,
    OP_BTST = 3'd5
  } io_op_e;

  // read/write storage locations; pin capture is kept separate
  localparam logic [ADDR_W-1:0] STORE_ADDR [NUM_STORE] = '{
    6'h3F, 6'h3B, 6'h3A, 6'h39, 6'h38, 6'h33, 6'h32, 6'h18, 6'h17, 6'h08
  };
  localparam logic [ADDR_W-1:0] PIN_ADDR = 6'h16;

  function automatic logic [DATA_W-1:0] bit_update(
      input logic [DATA_W-1:0] old_val,
      input logic [BIDX_W-1:0] idx,
      input logic              make_one);
    logic [DATA_W-1:0] mask;
    mask = {{(DATA_W-1){1'b0}}, 1'b1} << idx;
    return make_one ? (old_val | mask) : (old_val & ~mask);
  endfunction

  function automatic logic is_bit_op(input io_op_e o);
    return (o == OP_BSET) || (o == OP_BCLR) || (o == OP_BTST);
  endfunction
endpackage

// File: rtl/io_addr_decode.sv
module io_addr_decode
  import io_space_pkg::*;
(
  input  logic [ADDR_W-1:0]    addr,
  output logic [NUM_STORE-1:0] store_hit,
  output logic                 pin_hit,
  output logic                 mapped,
  output logic                 low_half
);
  for (genvar g = 0; g < NUM_STORE; g++) begin : g_hit
    assign store_hit[g] = (addr == STORE_ADDR[g]);
  end

  assign pin_hit  = (addr == PIN_ADDR);
  assign mapped   = (|store_hit) | pin_hit;
  assign low_half = ~addr[ADDR_W-1];
endmodule

// File: rtl/io_store_slot.sv
module io_store_slot
  import io_space_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit,
  input  logic              low_half,
  input  io_op_e            op,
  input  logic [BIDX_W-1:0] bit_idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);
  logic wr_w, bset_w, bclr_w;

  assign wr_w   = hit && (op == OP_OUT);
  assign bset_w = hit && low_half && (op == OP_BSET);
  assign bclr_w = hit && low_half && (op == OP_BCLR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= '0;
    else if (wr_w)   q <= wdata;
    else if (bset_w) q <= bit_update(q, bit_idx, 1'b1);
    else if (bclr_w) q <= bit_update(q, bit_idx, 1'b0);
  end

  assert_out_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_w |=> (q == $past(wdata)));

  assert_bit_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bset_w |=> (q[$past(bit_idx)] && ((q | ({{(DATA_W-1){1'b0}}, 1'b1} << $past(bit_idx)))
                == ($past(q) | ({{(DATA_W-1){1'b0}}, 1'b1} << $past(bit_idx))))));

  assert_bit_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bclr_w |=> (!q[$past(bit_idx)] && ((q | ({{(DATA_W-1){1'b0}}, 1'b1} << $past(bit_idx)))
                == ($past(q) | ({{(DATA_W-1){1'b0}}, 1'b1} << $past(bit_idx))))));

  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit) |=> $stable(q));
endmodule

// File: rtl/io_reg_space.sv
module io_reg_space
  import io_space_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [2:0]        op,
  input  logic [BIDX_W-1:0] bit_idx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] pins_in,
  output logic [DATA_W-1:0] rdata,
  output logic              test_bit,
  output logic              illegal_op
);
  io_op_e                             op_e;
  logic [NUM_STORE-1:0]               store_hit;
  logic                               pin_hit, mapped, low_half;
  logic [NUM_STORE-1:0][DATA_W-1:0]   slot_q;
  logic [DATA_W-1:0]                  pin_q;
  logic [DATA_W-1:0]                  rd_any;
  logic                               upper_bitop_w;
  logic                               illegal_q;

  assign op_e = io_op_e'(op);

  io_addr_decode u_decode (
    .addr      (addr),
    .store_hit (store_hit),
    .pin_hit   (pin_hit),
    .mapped    (mapped),
    .low_half  (low_half)
  );

  for (genvar g = 0; g < NUM_STORE; g++) begin : g_slot
    io_store_slot u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .hit      (store_hit[g]),
      .low_half (low_half),
      .op       (op_e),
      .bit_idx  (bit_idx),
      .wdata    (wdata),
      .q        (slot_q[g])
    );
  end

  // read-only pin capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= '0;
    else        pin_q <= pins_in;
  end

  always_comb begin
    rd_any = '0;
    for (int i = 0; i < NUM_STORE; i++)
      if (store_hit[i]) rd_any = rd_any | slot_q[i];
    if (pin_hit) rd_any = rd_any | pin_q;
  end

  assign rdata    = (op_e == OP_IN) ? rd_any : '0;
  assign test_bit = (op_e == OP_BTST) && low_half && rd_any[bit_idx];

  assign upper_bitop_w = is_bit_op(op_e) && !low_half;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) illegal_q <= 1'b0;
    else        illegal_q <= upper_bitop_w;
  end
  assign illegal_op = illegal_q;

  assert_reserved_write_dropped_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((op_e == OP_OUT) && !mapped) |=> $stable(slot_q));

  assert_upper_bitop_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    upper_bitop_w |=> ($stable(slot_q) && illegal_op));

  assert_illegal_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_op |-> $past(is_bit_op(op_e) && addr[ADDR_W-1]));

  assert_test_upper_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    addr[ADDR_W-1] |-> !test_bit);

  assert_rdata_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_e != OP_IN) |-> (rdata == '0));

  assert_reserved_read_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((op_e == OP_IN) && !mapped) |-> (rdata == '0));
endmodule

// File: tb/test_io_reg_space.sv
module test_io_reg_space;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] addr = '0;
  logic [2:0] op = '0;
  logic [2:0] bit_idx = '0;
  logic [7:0] wdata = '0;
  logic [7:0] pins_in = '0;
  logic [7:0] rdata;
  logic       test_bit, illegal_op;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;
  logic [7:0] model [64];
  logic [7:0] pin_model;

  always #10 clk = ~clk;   // 50 MHz

  io_reg_space i_io_reg_space (
    .clk(clk), .rst_n(rst_n), .addr(addr), .op(op), .bit_idx(bit_idx),
    .wdata(wdata), .pins_in(pins_in), .rdata(rdata),
    .test_bit(test_bit), .illegal_op(illegal_op)
  );

  function automatic bit storage_loc(input int a);
    case (a)
      'h08, 'h17, 'h18, 'h32, 'h33, 'h38, 'h39, 'h3A, 'h3B, 'h3F: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [7:0] expect_read(input int a);
    if (a == 'h16)      return pin_model;
    if (storage_loc(a)) return model[a];
    return 8'h00;
  endfunction

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h (addr %02h op %0d bit %0d)",
               req, got, exp, addr, op, bit_idx);
    end
  endtask

  // present one operation at the falling edge, let outputs settle
  task automatic issue(input logic [2:0] o, input int a, input int b, input logic [7:0] d);
    @(negedge clk);
    op = o; addr = a[5:0]; bit_idx = b[2:0]; wdata = d;
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    for (int a = 0; a < 64; a++) model[a] = 8'h00;
    pin_model = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 / R3 / R10: reset state, full read sweep
    issue(3'd0, 0, 0, 8'h00);
    chk("R1 illegal_op after reset", {7'd0, illegal_op}, 8'h00);
    chk("R10 rdata idle", rdata, 8'h00);
    for (int a = 0; a < 64; a++) begin
      issue(3'd1, a, 0, 8'h00);
      chk(storage_loc(a) ? "R1 reset value" : "R3 reserved read", rdata, expect_read(a));
    end

    // R9: pin capture
    pins_in = 8'hA5;
    issue(3'd0, 0, 0, 8'h00);
    pin_model = 8'hA5;
    issue(3'd1, 'h16, 0, 8'h00);
    chk("R9 pin read", rdata, 8'hA5);

    // R2 / R4 / R9 / R10: write every address, then read every address
    for (int a = 0; a < 64; a++) begin
      logic [7:0] v;
      v = 8'(a * 37 + 5);
      issue(3'd2, a, 0, v);
      chk("R10 rdata during OUT", rdata, 8'h00);
      if (storage_loc(a)) model[a] = v;
    end
    for (int a = 0; a < 64; a++) begin
      issue(3'd1, a, 0, 8'h00);
      chk(storage_loc(a) ? "R2 write/read" :
          (a == 'h16 ? "R9 pin write ignored" : "R4 reserved write"), rdata, expect_read(a));
    end

    // R5 / R6 / R7 / R9: every bit of every lower-half address
    for (int a = 0; a < 32; a++) begin
      for (int b = 0; b < 8; b++) begin
        issue(3'd3, a, b, 8'hFF);
        if (storage_loc(a)) model[a][b] = 1'b1;
        issue(3'd5, a, b, 8'h00);
        chk("R5 set then R7 test", {7'd0, test_bit}, {7'd0, expect_read(a)[b]});
        issue(3'd1, a, 0, 8'h00);
        chk("R5 other bits kept", rdata, expect_read(a));
        issue(3'd4, a, b, 8'h00);
        if (storage_loc(a)) model[a][b] = 1'b0;
        issue(3'd5, a, b, 8'h00);
        chk("R6 clear then R7 test", {7'd0, test_bit}, {7'd0, expect_read(a)[b]});
        issue(3'd1, a, 0, 8'h00);
        chk("R6 other bits kept", rdata, expect_read(a));
      end
    end

    // R8 / R7: bit operations in the upper half
    for (int a = 32; a < 64; a++) begin
      logic [2:0] o;
      o = 3'd3 + 3'(a % 3);
      issue(o, a, a % 8, 8'h00);
      chk("R7 upper test zero", {7'd0, test_bit}, 8'h00);
      chk("R8 flag not yet", {7'd0, illegal_op}, 8'h00);
      issue(3'd0, a, 0, 8'h00);
      chk("R8 flag raised", {7'd0, illegal_op}, 8'h01);
      issue(3'd1, a, 0, 8'h00);
      chk("R8 flag one cycle", {7'd0, illegal_op}, 8'h00);
      chk("R8 location unchanged", rdata, expect_read(a));
    end

    // R9: pin follows input, bit set on 0x16 ignored
    pins_in = 8'h3C;
    issue(3'd3, 'h16, 0, 8'h00);
    pin_model = 8'h3C;
    issue(3'd1, 'h16, 0, 8'h00);
    chk("R9 pin set ignored", rdata, 8'h3C);
    chk("R8 no flag for low-half op", {7'd0, illegal_op}, 8'h00);

    // R1: reset again clears storage
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    issue(3'd1, 'h3F, 0, 8'h00);
    chk("R1 reset clears", rdata, 8'h00);
    issue(3'd1, 'h18, 0, 8'h00);
    chk("R1 reset clears", rdata, 8'h00);

    finish_run();
  end
endmodule